// File: doc/BRIEF.md
# Prioritized Address Window Translator

This block maps a 32-bit local-bus address onto a PCI bus address and cycle type. Three programmable windows are available. Windows 0 and 1 are general-purpose. Each has a size that can be set from 1 MB to 2 GB, and each can produce any cycle type. Window 2 is fixed at 16 MB and always issues I/O cycles. Software programs the windows through a simple write port. Each window takes one base word, which sets where it matches and how, and one map word, which sets where it lands on the PCI side.

A lookup address is presented every cycle. One cycle later the block returns its result:
- a hit flag;
- the index of the window that matched;
- the translated PCI address;
- the cycle type;
- a prefetch flag;
- whether address bits 1:0 were passed through.

Windows may overlap. The lowest-numbered matching window always wins. This lets software enlarge window 0 so that it covers window 1, reprogram window 1 while it is hidden, and then shrink window 0 again.

Top module: `addr_window_xlate`

## Requirements
- R1: After reset every window is disabled, so every lookup returns a miss.
- R2: The result for the address on `lk_addr` appears on the outputs one clock later. A register write takes effect from the lookup in the cycle after the write. A lookup presented in the same cycle as the write still sees the old setting.
- R3: `wr_sel` selects the target register: 0 window-0 base, 1 window-0 map, 2 window-1 base, 3 window-1 map, 4 window-2 base, 5 window-2 map. Writes with `wr_sel` 6 or 7 change nothing.
- R4: A window 0/1 base word holds the following fields, and all its other bits (including 9:8) have no effect:
  - bits 31:20: base address;
  - bits 7:4: size code;
  - bit 3: prefetch flag;
  - bit 0: enable.
- R5: Size code c gives a span of 2^(20+c) bytes for c = 0..11, and codes 12..15 act as 2 GB. A window matches when the local address and the base agree on every bit above the span. Base bits inside the span are ignored.
- R6: In a window 0/1 map word:
  - bits 15:4 supply PCI address bits 31:20 above the span, and the local address supplies the bits below it;
  - bits 3:1 appear unchanged on `res_cycle` (0 interrupt acknowledge, 1 I/O, 3 memory, 5 configuration, 6 memory-multiple).
- R7: Map bit 0 is the low-address enable. When it is 0, PCI bits 1:0 are 0. When it is 1, they copy local bits 1:0. `res_low_en` reports the setting.
- R8: Window 2 is enabled by base bit 0 and matches when base bits 15:8 equal local bits 31:24. On a match:
  - PCI address = {map bits 15:8, local bits 23:0};
  - cycle type = 1;
  - prefetch = 0;
  - `res_low_en` = 1.
- R9: The lowest-index enabled matching window wins.
- R10: On a miss, `res_hit` is 0 and `res_win`, `res_pci_addr`, `res_cycle`, `res_prefetch` and `res_low_en` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 3 | Register select (R3) |
| wr_data | input | 32 | Register write data |
| lk_addr | input | 32 | Local-bus address to translate |
| res_hit | output | 1 | A window matched |
| res_win | output | 2 | Index of the winning window |
| res_pci_addr | output | 32 | Translated PCI address |
| res_cycle | output | 3 | PCI cycle type |
| res_prefetch | output | 1 | Winning window is prefetchable |
| res_low_en | output | 1 | PCI bits 1:0 follow the local address |

## Verification
The bench sweeps all sixteen size codes, using a base word with junk inside the span and stray bits set elsewhere, and flips each address bit in turn around the base. A design that decoded the span off by one bit, or compared base bits inside the span, would misjudge the hit boundary and return wrong low address bits. Overlap configurations check that a design with a reversed or missing priority picks the hidden window. A write and a lookup are issued in the same cycle, which catches a design whose register updates bypass into the lookup path. Disabled windows, writes with the unused select codes, and misses are also checked, so a design that leaks stale values on a miss is reported.

// File: rtl/addr_window_xlate.sv
module addr_window_xlate #(
  parameter int MIN_SPAN_LOG2 = 20,
  parameter int MAX_CODE      = 11,
  parameter int IO_SPAN_LOG2  = 24
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  logic [2:0]  wr_sel,
  input  logic [31:0] wr_data,
  input  logic [31:0] lk_addr,
  output logic        res_hit,
  output logic [1:0]  res_win,
  output logic [31:0] res_pci_addr,
  output logic [2:0]  res_cycle,
  output logic        res_prefetch,
  output logic        res_low_en
);
  localparam int HI_W = 32 - MIN_SPAN_LOG2;
  localparam int IO_W = 32 - IO_SPAN_LOG2;

  logic [HI_W-1:0] base_hi [2];
  logic [3:0]      size_c  [2];
  logic            pref    [2];
  logic            en      [2];
  logic [HI_W-1:0] map_hi  [2];
  logic [2:0]      ctype   [2];
  logic            low     [2];
  logic [IO_W-1:0] io_base, io_map;
  logic            io_en;

  logic            unused_bits;
  assign unused_bits = ^wr_data[MIN_SPAN_LOG2-1:16];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < 2; i++) begin
        base_hi[i] <= '0; size_c[i] <= '0; pref[i] <= 1'b0; en[i] <= 1'b0;
        map_hi[i]  <= '0; ctype[i]  <= '0; low[i]  <= 1'b0;
      end
      io_base <= '0; io_map <= '0; io_en <= 1'b0;
    end else if (wr_en) begin
      for (int i = 0; i < 2; i++) begin
        if (wr_sel == 3'(2*i)) begin
          base_hi[i] <= wr_data[31:MIN_SPAN_LOG2];
          size_c[i]  <= wr_data[7:4];
          pref[i]    <= wr_data[3];
          en[i]      <= wr_data[0];
        end
        if (wr_sel == 3'(2*i+1)) begin
          map_hi[i] <= wr_data[15:16-HI_W];
          ctype[i]  <= wr_data[3:1];
          low[i]    <= wr_data[0];
        end
      end
      if (wr_sel == 3'd4) begin
        io_base <= wr_data[15:16-IO_W];
        io_en   <= wr_data[0];
      end
      if (wr_sel == 3'd5) io_map <= wr_data[15:16-IO_W];
    end
  end

  logic [31:0] mask [2];
  logic [31:0] xl   [2];
  logic [1:0]  win_hit;
  logic        io_hit;

  always_comb begin
    for (int i = 0; i < 2; i++) begin
      mask[i] = 32'hFFFF_FFFF << (MIN_SPAN_LOG2 +
                ((int'(size_c[i]) > MAX_CODE) ? MAX_CODE : int'(size_c[i])));
      win_hit[i] = en[i] &&
                   (((lk_addr ^ {base_hi[i], {MIN_SPAN_LOG2{1'b0}}}) & mask[i]) == 32'h0);
      xl[i] = ({map_hi[i], {MIN_SPAN_LOG2{1'b0}}} & mask[i]) | (lk_addr & ~mask[i]);
      if (!low[i]) xl[i][1:0] = 2'b00;
    end
  end

  assign io_hit = io_en && (lk_addr[31:IO_SPAN_LOG2] == io_base);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_hit <= 1'b0; res_win <= '0; res_pci_addr <= '0;
      res_cycle <= '0; res_prefetch <= 1'b0; res_low_en <= 1'b0;
    end else if (win_hit[0] || win_hit[1]) begin
      res_hit      <= 1'b1;
      res_win      <= win_hit[0] ? 2'd0 : 2'd1;
      res_pci_addr <= win_hit[0] ? xl[0] : xl[1];
      res_cycle    <= win_hit[0] ? ctype[0] : ctype[1];
      res_prefetch <= win_hit[0] ? pref[0] : pref[1];
      res_low_en   <= win_hit[0] ? low[0] : low[1];
    end else if (io_hit) begin
      res_hit      <= 1'b1;
      res_win      <= 2'd2;
      res_pci_addr <= {io_map, lk_addr[IO_SPAN_LOG2-1:0]};
      res_cycle    <= 3'd1;
      res_prefetch <= 1'b0;
      res_low_en   <= 1'b1;
    end else begin
      res_hit <= 1'b0; res_win <= '0; res_pci_addr <= '0;
      res_cycle <= '0; res_prefetch <= 1'b0; res_low_en <= 1'b0;
    end
  end

  a_r10_miss_zero: assert property (@(posedge clk) disable iff (!rst_n)
    !res_hit |-> (res_win == 2'd0 && res_pci_addr == 32'h0 && res_cycle == 3'd0
                  && !res_prefetch && !res_low_en));
  a_r9_lower_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (res_hit && res_win != 2'd0) |-> !$past(win_hit[0]));
  a_r7_low_forced: assert property (@(posedge clk) disable iff (!rst_n)
    (res_hit && !res_low_en) |-> res_pci_addr[1:0] == 2'b00);
  a_r8_io_attrs: assert property (@(posedge clk) disable iff (!rst_n)
    (res_hit && res_win == 2'd2) |-> (res_cycle == 3'd1 && !res_prefetch && res_low_en
      && res_pci_addr[IO_SPAN_LOG2-1:0] == $past(lk_addr[IO_SPAN_LOG2-1:0])));
  a_r9_win_range: assert property (@(posedge clk) disable iff (!rst_n)
    res_hit |-> res_win != 2'd3);
endmodule

// File: tb/addr_window_xlate_tb_top.sv
module addr_window_xlate_tb_top;
  logic clk = 1'b0, rst_n = 1'b0, wr_en = 1'b0;
  logic [2:0]  wr_sel = '0;
  logic [31:0] wr_data = '0, lk_addr = '0;
  logic res_hit, res_prefetch, res_low_en;
  logic [1:0] res_win;
  logic [31:0] res_pci_addr;
  logic [2:0] res_cycle;
  int n_chk = 0, n_bad = 0;
  bit done = 1'b0;

  logic [31:0] sb [2];
  logic [15:0] sm [2];
  logic [15:0] s_iob, s_iom;

  always #5 clk = ~clk;

  addr_window_xlate dut_i (.clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel),
    .wr_data(wr_data), .lk_addr(lk_addr), .res_hit(res_hit), .res_win(res_win),
    .res_pci_addr(res_pci_addr), .res_cycle(res_cycle), .res_prefetch(res_prefetch),
    .res_low_en(res_low_en));

  function automatic void predict(input logic [31:0] a, output logic h, output logic [1:0] w,
      output logic [31:0] p, output logic [2:0] cy, output logic pf, output logic le);
    logic found = 1'b0;
    h = 0; w = 0; p = 0; cy = 0; pf = 0; le = 0;
    for (int k = 0; k < 2; k++) begin
      longint unsigned span, code, pa;
      code = longint'(sb[k][7:4]);
      if (code > 11) code = 11;
      span = 64'd1 << (20 + code);
      if (!found && sb[k][0] && (longint'(a) / span) == (longint'({sb[k][31:20], 20'h0}) / span)) begin
        found = 1'b1;
        pa = (longint'({sm[k][15:4], 20'h0}) / span) * span + longint'(a) % span;
        if (!sm[k][0]) pa = pa - pa % 4;
        h = 1; w = 2'(k); p = pa[31:0]; cy = sm[k][3:1]; pf = sb[k][3]; le = sm[k][0];
      end
    end
    if (!found && s_iob[0] && a[31:24] == s_iob[15:8]) begin
      h = 1; w = 2; p = s_iom[15:8] * 32'h0100_0000 + a % 32'h0100_0000; cy = 1; pf = 0; le = 1;
    end
  endfunction

  task automatic shadow(input logic [2:0] s, input logic [31:0] d);
    case (s)
      3'd0: sb[0] = d;  3'd1: sm[0] = d[15:0];
      3'd2: sb[1] = d;  3'd3: sm[1] = d[15:0];
      3'd4: s_iob = d[15:0];  3'd5: s_iom = d[15:0];
      default: ;
    endcase
  endtask

  task automatic wr(input logic [2:0] s, input logic [31:0] d);
    @(negedge clk); wr_en = 1; wr_sel = s; wr_data = d;
    @(negedge clk); wr_en = 0;
    shadow(s, d);
  endtask

  task automatic compare(input string tag, input logic [31:0] a, input logic h, input logic [1:0] w,
      input logic [31:0] p, input logic [2:0] cy, input logic pf, input logic le);
    n_chk++;
    if (res_hit !== h || res_win !== w || res_pci_addr !== p || res_cycle !== cy ||
        res_prefetch !== pf || res_low_en !== le) begin
      n_bad++;
      $display("FAIL %s addr=%h actual hit=%b win=%0d pci=%h cy=%0d pf=%b le=%b expected hit=%b win=%0d pci=%h cy=%0d pf=%b le=%b",
        tag, a, res_hit, res_win, res_pci_addr, res_cycle, res_prefetch, res_low_en, h, w, p, cy, pf, le);
    end
  endtask

  task automatic look(input string tag, input logic [31:0] a);
    logic h, pf, le; logic [1:0] w; logic [31:0] p; logic [2:0] cy;
    @(negedge clk); lk_addr = a;
    predict(a, h, w, p, cy, pf, le);
    @(negedge clk);
    compare(tag, a, h, w, p, cy, pf, le);
  endtask

  task automatic sweep(input string tag);
    for (int i = 0; i < 256; i++)
      look(tag, (32'(i) << 24) + ((32'(i) * 32'h0003_1F07) & 32'h00FF_FFFF));
    for (int k = 0; k < 2; k++) begin
      longint unsigned code, span, b;
      code = longint'(sb[k][7:4]);
      if (code > 11) code = 11;
      span = 64'd1 << (20 + code);
      b = (longint'({sb[k][31:20], 20'h0}) / span) * span;
      look(tag, b[31:0]); look(tag, b[31:0] - 1);
      look(tag, 32'(b + span - 1)); look(tag, 32'(b + span));
    end
  endtask

  initial begin
    #(10 * 150000);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    sb[0] = 0; sb[1] = 0; sm[0] = 0; sm[1] = 0; s_iob = 0; s_iom = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1: nothing enabled after reset
    sweep("R1");
    // R4 R6 R8: normal layout, memory windows plus I/O window
    wr(3'd0, 32'h4000_0000 | (8 << 4) | 1);
    wr(3'd1, 32'h1000 | (3 << 1));
    wr(3'd2, 32'h5000_0000 | (8 << 4) | 8 | 1);
    wr(3'd3, 32'h2000 | (6 << 1) | 1);
    wr(3'd4, 32'h6000 | 1);
    wr(3'd5, 32'hA500);
    sweep("R6");
    look("R8", 32'h60AB_CDEF); look("R8", 32'h6000_0003);
    look("R7", 32'h5123_4567); look("R7", 32'h4FFF_FFFF);
    // R9: enlarge window 0 to hide window 1, then window 1 covers window 2
    wr(3'd0, 32'h4000_0000 | (9 << 4) | 1);
    wr(3'd2, 32'h5000_0000 | (4 << 4) | 1);
    wr(3'd3, 32'h0000 | (5 << 1) | 1);
    sweep("R9");
    wr(3'd2, 32'h6000_0000 | (5 << 4) | 1);
    sweep("R9");
    look("R9", 32'h6080_0001); look("R9", 32'h61FF_FFFE);
    // R3: unused select codes change nothing
    wr(3'd6, 32'hFFFF_FFFF);
    wr(3'd7, 32'h0000_0000);
    sweep("R3");
    // R10: disable windows in turn
    wr(3'd0, 32'h4000_0000 | (9 << 4));
    sweep("R10");
    wr(3'd2, 32'h6000_0000 | (5 << 4));
    wr(3'd4, 32'h6000);
    sweep("R10");
    // R5 R4: every size code, junk in span and in ignored fields
    for (int c = 0; c < 16; c++) begin
      wr(3'd0, 32'h8765_4321 & 32'hFFF0_0000 | 32'h0005_0306 | (32'(c) << 4) | (32'(c & 1) << 3) | 1);
      wr(3'd1, 32'hABC0 | (32'(c % 8) << 1) | 32'(c & 1));
      for (int k = 0; k < 32; k++) begin
        look("R5", 32'h8765_4321 ^ (32'h1 << k));
        look("R5", 32'h8760_0000 ^ (32'h1 << k));
      end
      sweep("R5");
    end
    // R2: write and lookup in the same cycle see the old setting
    begin
      logic h, pf, le; logic [1:0] w; logic [31:0] p; logic [2:0] cy;
      @(negedge clk);
      wr_en = 1; wr_sel = 3'd0; wr_data = 32'h1230_0001; lk_addr = 32'h1230_0044;
      predict(32'h1230_0044, h, w, p, cy, pf, le);
      @(negedge clk); wr_en = 0;
      compare("R2", 32'h1230_0044, h, w, p, cy, pf, le);
      shadow(3'd0, 32'h1230_0001);
      look("R2", 32'h1230_0044);
      look("R2", 32'h1240_0044);
    end
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule